// File: doc/BRIEF.md
# Dual-Input Edge Capture Unit

This block timestamps external events. Two capture pins, A and B, are each synchronized into the count clock domain and watched for the edges that the pin's own edge-select field asks for. When a qualifying edge is seen, the value of the chosen free-running counter is latched into that pin's capture register and the pin's capture flag goes high. If the flag was still high from an earlier, unacknowledged capture, the register is overwritten anyway and an overwrite flag records the lost sample.

The two counters are inputs to the block, each with a run indication. One source field picks which counter both pins sample. A comparator-mode bit turns capture off entirely, and no capture happens while the chosen counter is stopped. Software uses a small register bus to program the control word, read the two capture registers, and clear flags by writing ones to them. Each pin drives one interrupt line that combines its two flags with their enables.

Top module: `edge_stamp_unit`

## Requirements
- R1: Control bits [3:2] choose the edges for pin A and bits [5:4] for pin B: 0 captures nothing, 1 rising edges only, 2 falling edges only, 3 both edges. An edge of a kind that is not chosen leaves the capture register and the flags unchanged.
- R2: A chosen edge loads the counter value present before the third rising clock edge after the pin changes (two synchronizer stages plus one detect stage) into that pin's capture register (address 2 for A, address 3 for B) and sets its capture flag (status bit 0 for A, bit 2 for B).
- R3: Control bits [1:0] select the counter source by bit 0 alone: 0 or 2 picks counter 0, 1 or 3 picks counter 1. Both pins sample the same selected counter.
- R4: `irq_a` is high exactly when (A capture flag and control bit 7) or (A overwrite flag and control bit 8); `irq_b` likewise with the B flags and control bits 9 and 10.
- R5: A capture while that pin's capture flag is already set still loads the new value and sets its overwrite flag (status bit 1 for A, bit 3 for B).
- R6: While control bit 6 (comparator mode) is set, no capture occurs on either pin.
- R7: Writing the status register (address 1) clears each flag whose data bit is 1. A capture in the same cycle as a clear of its capture flag leaves the capture flag set and does not set the overwrite flag.
- R8: No capture occurs while the run input of the selected counter is low; an edge seen during that time is not captured later.
- R9: A pin that holds each level for at least four clock cycles has every chosen edge captured.
- R10: After reset all registers read zero and both interrupt lines are low. The control register is at address 0 and reads back bits [10:0] as written, upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt0_val | input | CNT_W | Value of counter 0 |
| cnt1_val | input | CNT_W | Value of counter 1 |
| cnt0_run | input | 1 | Counter 0 is counting |
| cnt1_run | input | 1 | Counter 1 is counting |
| cap_in_a | input | 1 | Asynchronous capture pin A |
| cap_in_b | input | 1 | Asynchronous capture pin B |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Register write data |
| bus_rdata | output | CNT_W | Register read data (combinational on address) |
| irq_a | output | 1 | Interrupt request for pin A |
| irq_b | output | 1 | Interrupt request for pin B |

## Verification
On every cycle the assertions check that the capture registers hold still while comparator mode is on, while the selected counter is stopped and while a pin's edge field is zero, that a changed capture register comes with a raised capture flag, that an overwrite flag only rises over a flag that was already set, and that an interrupt line stays low with both of its flags clear. The bench scenarios are needed for the exact captured values and their three-cycle latency, the choice of source counter including the aliased select codes, the write-one-to-clear collision with a capture, the loss of an edge seen while the counter was stopped, back-to-back four-cycle pulses, and the control readback.

// File: rtl/esu_pkg.sv
package esu_pkg;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_BOTH = 2'd3
   } edge_sel_e;

   // control word, msb first
   typedef struct packed {
      logic      ovr_ie_b;
      logic      cap_ie_b;
      logic      ovr_ie_a;
      logic      cap_ie_a;
      logic      cmp_mode;
      edge_sel_e esel_b;
      edge_sel_e esel_a;
      logic [1:0] src;
   } ctl_t;

   localparam int CTL_W  = $bits(ctl_t);
   localparam int REG_AW = 2;
   localparam int NUM_CH = 2;
   localparam int STS_W  = 2 * NUM_CH;

   localparam logic [REG_AW-1:0] ADDR_CTL  = 2'd0;
   localparam logic [REG_AW-1:0] ADDR_STS  = 2'd1;
   localparam logic [REG_AW-1:0] ADDR_CAPA = 2'd2;
   localparam logic [REG_AW-1:0] ADDR_CAPB = 2'd3;

endpackage

// File: rtl/esu_sync_edge.sv
module esu_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   // STAGES synchronizer flops plus one history flop
   logic [STAGES:0] pipe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-1:0], din};
   end

   assign rise =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
   assign fall = ~pipe_q[STAGES-1] &  pipe_q[STAGES];

endmodule

// File: rtl/esu_cap_chan.sv
module esu_cap_chan
   import esu_pkg::*;
#(
   parameter int W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise,
   input  logic          fall,
   input  edge_sel_e     esel,
   input  logic          arm,
   input  logic [W-1:0]  cnt,
   input  logic          clr_cap,
   input  logic          clr_ovr,
   output logic [W-1:0]  cap_val,
   output logic          cap_flag,
   output logic          ovr_flag
);
   logic edge_ok;
   logic hit;

   always_comb begin
      case (esel)
         EDGE_RISE: edge_ok = rise;
         EDGE_FALL: edge_ok = fall;
         EDGE_BOTH: edge_ok = rise | fall;
         default:   edge_ok = 1'b0;
      endcase
   end

   assign hit = arm & edge_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_val  <= '0;
         cap_flag <= 1'b0;
         ovr_flag <= 1'b0;
      end else begin
         if (hit) cap_val <= cnt;
         // capture beats a simultaneous clear
         cap_flag <= hit | (cap_flag & ~clr_cap);
         // an acknowledged flag does not count as lost data
         ovr_flag <= (hit & cap_flag & ~clr_cap) | (ovr_flag & ~clr_ovr);
      end
   end

endmodule

// File: rtl/esu_regs.sv
module esu_regs
   import esu_pkg::*;
#(
   parameter int W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [W-1:0]      bus_wdata,
   output logic [W-1:0]      bus_rdata,
   input  logic [STS_W-1:0]  sts,
   input  logic [W-1:0]      capv_a,
   input  logic [W-1:0]      capv_b,
   output ctl_t              ctl,
   output logic [STS_W-1:0]  clr
);
   ctl_t         ctl_q;
   logic [W-1:0] ctl_rd;
   logic [W-1:0] sts_rd;

   always_ff @(posedge clk) begin
      if (!rst_n)                              ctl_q <= '0;
      else if (bus_we && bus_addr == ADDR_CTL) ctl_q <= ctl_t'(bus_wdata[CTL_W-1:0]);
   end

   assign ctl = ctl_q;
   assign clr = (bus_we && bus_addr == ADDR_STS) ? bus_wdata[STS_W-1:0] : '0;

   generate
      if (W > CTL_W) begin : g_ctl_pad
         assign ctl_rd = {{(W-CTL_W){1'b0}}, ctl_q};
      end else begin : g_ctl_full
         assign ctl_rd = W'(ctl_q);
      end
      if (W > STS_W) begin : g_sts_pad
         assign sts_rd = {{(W-STS_W){1'b0}}, sts};
      end else begin : g_sts_full
         assign sts_rd = W'(sts);
      end
   endgenerate

   always_comb begin
      case (bus_addr)
         ADDR_CTL:  bus_rdata = ctl_rd;
         ADDR_STS:  bus_rdata = sts_rd;
         ADDR_CAPA: bus_rdata = capv_a;
         default:   bus_rdata = capv_b;
      endcase
   end

endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
   import esu_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt0_val,
   input  logic [CNT_W-1:0]  cnt1_val,
   input  logic              cnt0_run,
   input  logic              cnt1_run,
   input  logic              cap_in_a,
   input  logic              cap_in_b,
   input  logic              bus_we,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              irq_a,
   output logic              irq_b
);
   generate
      if (CNT_W < CTL_W) begin : g_chk_width
         $error("edge_stamp_unit: CNT_W must cover the control word");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("edge_stamp_unit: SYNC_STAGES must be at least 2");
      end
   endgenerate

   ctl_t             ctl;
   logic [STS_W-1:0] clr;
   logic [STS_W-1:0] sts;

   logic [CNT_W-1:0] sel_cnt;
   logic             sel_run;
   logic             cmp_on;
   logic             arm;

   logic [NUM_CH-1:0] pin, rise, fall, cflag, oflag, cap_ie, ovr_ie, irq_vec;
   edge_sel_e         esel   [NUM_CH];
   logic [CNT_W-1:0]  capv   [NUM_CH];

   edge_sel_e        esel_a, esel_b;
   logic [CNT_W-1:0] capv_a, capv_b;

   assign sel_cnt = ctl.src[0] ? cnt1_val : cnt0_val;
   assign sel_run = ctl.src[0] ? cnt1_run : cnt0_run;
   assign cmp_on  = ctl.cmp_mode;
   assign arm     = sel_run & ~cmp_on;

   assign pin     = {cap_in_b, cap_in_a};
   assign esel[0] = ctl.esel_a;
   assign esel[1] = ctl.esel_b;
   assign cap_ie  = {ctl.cap_ie_b, ctl.cap_ie_a};
   assign ovr_ie  = {ctl.ovr_ie_b, ctl.ovr_ie_a};

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         esu_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pin[ch]),
            .rise (rise[ch]),
            .fall (fall[ch])
         );

         esu_cap_chan #(.W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise    (rise[ch]),
            .fall    (fall[ch]),
            .esel    (esel[ch]),
            .arm     (arm),
            .cnt     (sel_cnt),
            .clr_cap (clr[2*ch]),
            .clr_ovr (clr[2*ch+1]),
            .cap_val (capv[ch]),
            .cap_flag(cflag[ch]),
            .ovr_flag(oflag[ch])
         );

         assign sts[2*ch]   = cflag[ch];
         assign sts[2*ch+1] = oflag[ch];
         assign irq_vec[ch] = (cflag[ch] & cap_ie[ch]) | (oflag[ch] & ovr_ie[ch]);
      end
   endgenerate

   assign esel_a = esel[0];
   assign esel_b = esel[1];
   assign capv_a = capv[0];
   assign capv_b = capv[1];
   assign irq_a  = irq_vec[0];
   assign irq_b  = irq_vec[1];

   esu_regs #(.W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .sts      (sts),
      .capv_a   (capv_a),
      .capv_b   (capv_b),
      .ctl      (ctl),
      .clr      (clr)
   );

endmodule

// File: rtl/esu_checker.sv
module esu_checker
   import esu_pkg::*;
#(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cmp_on,
   input logic         sel_run,
   input edge_sel_e    esel_a,
   input edge_sel_e    esel_b,
   input logic [W-1:0] capv_a,
   input logic [W-1:0] capv_b,
   input logic         cflag_a,
   input logic         cflag_b,
   input logic         oflag_a,
   input logic         oflag_b,
   input logic         irq_a,
   input logic         irq_b
);
   assert_cmp_holds_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_on |=> $stable(capv_a));
   assert_cmp_holds_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_on |=> $stable(capv_b));

   assert_stop_holds_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_run |=> $stable(capv_a));
   assert_stop_holds_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_run |=> $stable(capv_b));

   assert_none_holds_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (esel_a == EDGE_NONE) |=> $stable(capv_a));
   assert_none_holds_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (esel_b == EDGE_NONE) |=> $stable(capv_b));

   assert_load_flags_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(capv_a) |-> cflag_a);
   assert_load_flags_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(capv_b) |-> cflag_b);

   assert_ovr_needs_flag_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oflag_a) |-> $past(cflag_a));
   assert_ovr_needs_flag_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oflag_b) |-> $past(cflag_b));

   assert_irq_quiet_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(cflag_a || oflag_a) |-> !irq_a);
   assert_irq_quiet_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(cflag_b || oflag_b) |-> !irq_b);

endmodule

bind edge_stamp_unit esu_checker #(.W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cmp_on (cmp_on),
   .sel_run(sel_run),
   .esel_a (esel_a),
   .esel_b (esel_b),
   .capv_a (capv_a),
   .capv_b (capv_b),
   .cflag_a(cflag[0]),
   .cflag_b(cflag[1]),
   .oflag_a(oflag[0]),
   .oflag_b(oflag[1]),
   .irq_a  (irq_a),
   .irq_b  (irq_b)
);

// File: tb/edge_stamp_unit_tb.sv
module edge_stamp_unit_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      int          kind;   // 0: read data, 1: {irq_b, irq_a}
      logic [15:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] tick;
   logic        run0 = 1'b1, run1 = 1'b1;
   logic        cap_a = 1'b0, cap_b = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        irq_a, irq_b;

   item_t sb_q[$];
   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   logic [15:0] exp_a = 16'd0, exp_b = 16'd0, t0, t1;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_ff @(posedge clk) begin
      if (!rst_n) tick <= 16'd0;
      else        tick <= tick + 16'd1;
   end

   edge_stamp_unit u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt0_val (tick),
      .cnt1_val (~tick),
      .cnt0_run (run0),
      .cnt1_run (run1),
      .cap_in_a (cap_a),
      .cap_in_b (cap_b),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .irq_a    (irq_a),
      .irq_b    (irq_b)
   );

   // value captured for an edge driven while tick read t (three edges later)
   function automatic logic [15:0] cap_of(input logic [1:0] src, input logic [15:0] t);
      logic [15:0] v;
      v = t + 16'd2;
      return src[0] ? ~v : v;
   endfunction

   // monitor: compares queued expectations away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb_q.pop_front();
            act = (it.kind == 0) ? bus_rdata : {14'd0, irq_b, irq_a};
            vectors++;
            if (act !== it.exp) begin
               miscompares++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic chk_rd(input logic [1:0] a, input logic [15:0] e, input string tag);
      @(negedge clk);
      bus_addr = a;
      sb_q.push_back('{0, e, tag});
   endtask

   task automatic chk_irq(input logic [1:0] e, input string tag);
      @(negedge clk);
      sb_q.push_back('{1, {14'd0, e}, tag});
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic drive(input int ch, input logic lvl, output logic [15:0] t);
      @(negedge clk);
      if (ch == 0) cap_a = lvl; else cap_b = lvl;
      t = tick;
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      chk_rd(2'd0, 16'h0000, "R10 ctl after reset");
      chk_rd(2'd1, 16'h0000, "R10 status after reset");
      chk_rd(2'd2, 16'h0000, "R10 capA after reset");
      chk_rd(2'd3, 16'h0000, "R10 capB after reset");
      chk_irq(2'b00, "R10 irq after reset");

      // src 0, A rising, B falling, A capture irq enabled
      wr(2'd0, 16'h00A4);
      chk_rd(2'd0, 16'h00A4, "R10 ctl readback");
      drive(0, 1'b1, t0); exp_a = cap_of(2'd0, t0);
      chk_rd(2'd2, exp_a, "R2 capA on rising");
      chk_rd(2'd1, 16'h0001, "R2 A flag set");
      chk_irq(2'b01, "R4 irq A from capture");
      drive(1, 1'b1, t0);
      chk_rd(2'd3, 16'h0000, "R1 B ignores rising");
      chk_rd(2'd1, 16'h0001, "R1 status after ignored B edge");
      drive(1, 1'b0, t0); exp_b = cap_of(2'd0, t0);
      chk_rd(2'd3, exp_b, "R1 capB on falling");
      chk_rd(2'd1, 16'h0005, "R2 B flag set");
      chk_irq(2'b01, "R4 irq B disabled");
      drive(0, 1'b0, t0);
      chk_rd(2'd2, exp_a, "R1 A ignores falling");
      drive(0, 1'b1, t0); exp_a = cap_of(2'd0, t0);
      chk_rd(2'd2, exp_a, "R5 capA overwritten");
      chk_rd(2'd1, 16'h0007, "R5 overwrite flag A");
      wr(2'd1, 16'h0003);
      chk_rd(2'd1, 16'h0004, "R7 clear A flags only");
      wr(2'd1, 16'h0004);
      chk_rd(2'd1, 16'h0000, "R7 clear B flag");
      chk_irq(2'b00, "R4 irq low after clear");

      // src 1, A both edges, B none, A overwrite irq enabled
      wr(2'd0, 16'h010D);
      drive(0, 1'b0, t0); exp_a = cap_of(2'd1, t0);
      chk_rd(2'd2, exp_a, "R3 capA from counter 1");
      chk_irq(2'b00, "R4 capture irq disabled");
      drive(0, 1'b1, t0); exp_a = cap_of(2'd1, t0);
      chk_rd(2'd2, exp_a, "R1 both-edge rising capture");
      chk_rd(2'd1, 16'h0003, "R5 overwrite on both-edge");
      chk_irq(2'b01, "R4 irq from overwrite flag");
      drive(1, 1'b1, t0);
      chk_rd(2'd3, exp_b, "R1 B none keeps register");
      wr(2'd1, 16'h000F);

      // R7 clear collides with capture
      drive(0, 1'b0, t0); exp_a = cap_of(2'd1, t0);
      chk_rd(2'd1, 16'h0001, "R7 flag before collision");
      @(negedge clk); cap_a = 1'b1; t0 = tick;
      @(negedge clk);
      @(negedge clk); bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h0003;
      @(negedge clk); bus_we = 1'b0;
      repeat (2) @(negedge clk);
      exp_a = cap_of(2'd1, t0);
      chk_rd(2'd2, exp_a, "R7 capture during clear");
      chk_rd(2'd1, 16'h0001, "R7 capture wins, no overwrite");
      wr(2'd1, 16'h000F);

      // R8 selected counter stopped
      @(negedge clk); run1 = 1'b0;
      drive(0, 1'b0, t0);
      @(negedge clk); run1 = 1'b1;
      repeat (4) @(negedge clk);
      chk_rd(2'd2, exp_a, "R8 no capture while stopped");
      chk_rd(2'd1, 16'h0000, "R8 no flag while stopped");

      // R6 comparator mode
      wr(2'd0, 16'h014D);
      drive(0, 1'b1, t0);
      wr(2'd0, 16'h010D);
      repeat (4) @(negedge clk);
      chk_rd(2'd2, exp_a, "R6 no capture in comparator mode");
      chk_rd(2'd1, 16'h0000, "R6 no flag in comparator mode");

      // R9 back-to-back four-cycle levels, src=3 aliases counter 1
      wr(2'd0, 16'h023F);
      @(negedge clk); cap_b = 1'b0; t0 = tick;
      repeat (4) @(negedge clk);
      cap_b = 1'b1; t1 = tick;
      repeat (4) @(negedge clk);
      exp_b = cap_of(2'd3, t1);
      chk_rd(2'd3, exp_b, "R9 second short edge captured");
      chk_rd(2'd1, 16'h000C, "R9 both short edges seen");
      chk_irq(2'b10, "R4 irq B from capture");

      // R10 upper control bits read zero
      wr(2'd0, 16'hFFFF);
      chk_rd(2'd0, 16'h07FF, "R10 ctl upper bits zero");

      done = 1;
      finish_run();
   end

endmodule